// File: doc/BRIEF.md
# Flash Write-Completion Poller

After a host has sent a program or erase command to a parallel flash device, this engine finds out when the device's internal operation has finished. It reads the affected address again and again through a simple request/valid read port. It judges each returned byte by one of two status methods. The first is a data-complement flag on bit 7. The second is a toggling flag on bit 6, which stops alternating once the operation ends. The engine then reports a one-cycle `done` pulse together with a held pass result and a held timeout flag.

The device finishes its work asynchronously to the host's reads. A read that lands just as the operation ends can therefore show a flag that says "finished" while the data bits still look wrong. When the engine sees such a conflicting byte, it reads the same location twice more, and it declares failure only if either of those reads is also wrong. In the bit-7 methods, the remaining data bits can lag the flag bit. The engine therefore waits a parameterised number of clock cycles (`SETTLE_CYC`, sized for about 1 µs) before it makes the full-byte compare.

Sending the command sequence itself is left to the surrounding logic. That logic starts this engine and hands it the final write strobe, so that polling begins only after that strobe's rising edge.

Top module: `wr_done_poller`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `pass`, `timeout` and `rd_req` are all 0.
- R2: `start` is accepted only when the engine is idle. Acceptance captures `mode`, `addr_in`, `exp_data` and `max_polls` and clears `pass` and `timeout`. A `start` raised while a job is running has no effect on that job's reads or result.
- R3: After a job is accepted, no read is issued until a rising edge (0 to 1) of `wr_strobe_n` has been seen.
- R4: Each read is a single-cycle `rd_req` pulse with `rd_addr` equal to the captured address. The engine then waits for `rd_valid` and issues no further request until the data returns.
- R5: Mode 2'b00 (program, bit-7 method): a read is busy while its bit 7 differs from bit 7 of the expected byte. The target for the full compare is the expected byte.
- R6: Mode 2'b01 (erase, bit-7 method): a read is busy while its bit 7 is 0. The target for the full compare is 8'hFF, whatever `exp_data` holds.
- R7: In both bit-7 modes, once a read shows the finished flag, the next read is issued no sooner than `SETTLE_CYC` cycles after that data returned. If that read equals the target, the job ends with pass.
- R8: Modes 2'b10 and 2'b11 (toggle method): the first read only records bit 6. A later read is busy if its bit 6 differs from the previous read's bit 6. The first read whose bit 6 matches the previous one is compared against the expected byte, and a match ends the job with pass.
- R9: If the full-byte compare of R7 or R8 mismatches, exactly two more reads follow. The job passes only if both of them equal the target; otherwise it fails with `timeout` at 0.
- R10: Each busy read counts once. The busy read that brings the count to `max_polls` (the first busy read when `max_polls` is 0) ends the job with `pass`=0 and `timeout`=1.
- R11: `done` is high for exactly one cycle per job, in the same cycle that `pass` and `timeout` take their final values. Both hold those values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a polling job (taken only when idle) |
| mode | input | 2 | 00 program/bit 7, 01 erase/bit 7, 1x toggle on bit 6 |
| addr_in | input | ADDR_W | Address to poll |
| exp_data | input | 8 | Byte that was written (unused as target in erase mode) |
| max_polls | input | CNT_W | Busy reads allowed before timeout |
| wr_strobe_n | input | 1 | Active-low write strobe of the final command cycle |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 8 | Returned byte |
| rd_valid | input | 1 | `rd_data` is valid this cycle |
| done | output | 1 | One-cycle end-of-job pulse |
| pass | output | 1 | Job result, held |
| timeout | output | 1 | Job ended by poll limit, held |

## Verification
Each result is due in a known cycle:
- `done`, `pass` and `timeout` change on the clock edge that samples the final `rd_valid`.
- A new request appears one edge after the previous data is taken.
- After a finished bit-7 flag, that gap is stretched by at least `SETTLE_CYC` cycles.
- `pass` and `timeout` clear one edge after an accepted `start`.

The bench drives and samples on the falling edge, half a cycle from the active edge. It time-stamps every request, every data return, the strobe rise and the `done` pulse, and then compares these stamps and the number of reads against a reference model of the requirements. It also re-samples the held results several cycles after `done`.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_REQ,
      ST_WAIT,
      ST_SETTLE
   } wdp_state_e;

   typedef enum logic [1:0] {
      PH_POLL,
      PH_FULL,
      PH_CONF
   } wdp_phase_e;

   localparam logic [7:0] ERASED_BYTE = 8'hFF;
   localparam int FLAG7_BIT  = 7;
   localparam int TOGGLE_BIT = 6;
endpackage

// File: rtl/wdp_status_eval.sv
module wdp_status_eval
   import wdp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              toggle_mode,
   input  logic              erase_mode,
   input  logic [DATA_W-1:0] exp_byte,
   input  logic [DATA_W-1:0] rd_byte,
   input  logic              prev_tog,
   output logic              flag_busy,
   output logic              full_match
);
   logic [DATA_W-1:0] target;

   always_comb begin
      target = erase_mode ? DATA_W'(ERASED_BYTE) : exp_byte;
      if (toggle_mode) begin
         flag_busy = rd_byte[TOGGLE_BIT] != prev_tog;
      end else begin
         flag_busy = rd_byte[FLAG7_BIT] != target[FLAG7_BIT];
      end
      full_match = rd_byte == target;
   end
endmodule

// File: rtl/wdp_poll_counter.sv
module wdp_poll_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic             last_allowed
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [EXT_W-1:0] next_ext;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("wdp_poll_counter: CNT_W must be at least 1");
      end
   endgenerate

   always_comb begin
      next_ext     = EXT_W'(cnt_q) + EXT_W'(1);
      last_allowed = next_ext >= EXT_W'(limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= next_ext[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/wdp_settle_timer.sv
module wdp_settle_timer #(
   parameter int SETTLE_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   generate
      if (SETTLE_CYC < 0) begin : g_bad_cyc
         $error("wdp_settle_timer: SETTLE_CYC must not be negative");
      end
      if (SETTLE_CYC == 0) begin : g_none
         assign expired = 1'b1;
      end else begin : g_count
         localparam int TW = $clog2(SETTLE_CYC + 1);
         logic [TW-1:0] left_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left_q <= '0;
            end else if (load) begin
               left_q <= TW'(SETTLE_CYC);
            end else if (left_q != '0) begin
               left_q <= left_q - TW'(1);
            end
         end

         assign expired = (left_q == '0) && !load;
      end
   endgenerate
endmodule

// File: rtl/wr_done_poller.sv
module wr_done_poller
   import wdp_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int CNT_W      = 16,
   parameter int SETTLE_CYC = 100,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] exp_data,
   input  logic [CNT_W-1:0]  max_polls,
   input  logic              wr_strobe_n,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_valid,
   output logic              done,
   output logic              pass,
   output logic              timeout
);
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("wr_done_poller: status bits assume DATA_W of 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("wr_done_poller: ADDR_W must be at least 1");
      end
   endgenerate

   wdp_state_e        state_q;
   wdp_phase_e        phase_q;
   logic              tog_q;
   logic              erase_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] exp_q;
   logic [CNT_W-1:0]  lim_q;
   logic              strobe_q;
   logic              prev_tog_q;
   logic              have_prev_q;
   logic              conf_second_q;
   logic              conf_ok_q;
   logic              done_q;
   logic              pass_q;
   logic              tmo_q;

   logic flag_busy;
   logic full_match;
   logic last_allowed;
   logic settle_done;

   logic take_start;
   logic got_data;
   logic poll_read;
   logic first_tog;
   logic busy_read;
   logic go_settle;
   logic conf_ok_nx;

   wdp_status_eval #(.DATA_W(DATA_W)) u_eval (
      .toggle_mode (tog_q),
      .erase_mode  (erase_q),
      .exp_byte    (exp_q),
      .rd_byte     (rd_data),
      .prev_tog    (prev_tog_q),
      .flag_busy   (flag_busy),
      .full_match  (full_match)
   );

   always_comb begin
      take_start = (state_q == ST_IDLE) && start;
      got_data   = (state_q == ST_WAIT) && rd_valid;
      poll_read  = got_data && (phase_q == PH_POLL);
      first_tog  = poll_read && tog_q && !have_prev_q;
      busy_read  = poll_read && !first_tog && flag_busy;
      go_settle  = poll_read && !first_tog && !flag_busy && !tog_q;
      conf_ok_nx = conf_ok_q && full_match;
   end

   wdp_poll_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (take_start),
      .inc          (busy_read),
      .limit        (lim_q),
      .last_allowed (last_allowed)
   );

   wdp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (go_settle),
      .expired (settle_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         phase_q       <= PH_POLL;
         tog_q         <= 1'b0;
         erase_q       <= 1'b0;
         addr_q        <= '0;
         exp_q         <= '0;
         lim_q         <= '0;
         strobe_q      <= 1'b1;
         prev_tog_q    <= 1'b0;
         have_prev_q   <= 1'b0;
         conf_second_q <= 1'b0;
         conf_ok_q     <= 1'b0;
         done_q        <= 1'b0;
         pass_q        <= 1'b0;
         tmo_q         <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         strobe_q <= wr_strobe_n;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  tog_q       <= mode[1];
                  erase_q     <= !mode[1] && mode[0];
                  addr_q      <= addr_in;
                  exp_q       <= exp_data;
                  lim_q       <= max_polls;
                  pass_q      <= 1'b0;
                  tmo_q       <= 1'b0;
                  have_prev_q <= 1'b0;
                  phase_q     <= PH_POLL;
                  state_q     <= ST_ARM;
               end
            end
            ST_ARM: begin
               if (wr_strobe_n && !strobe_q) begin
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: begin
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rd_valid) begin
                  unique case (phase_q)
                     PH_POLL: begin
                        if (first_tog) begin
                           prev_tog_q  <= rd_data[TOGGLE_BIT];
                           have_prev_q <= 1'b1;
                           state_q     <= ST_REQ;
                        end else if (flag_busy) begin
                           prev_tog_q <= rd_data[TOGGLE_BIT];
                           if (last_allowed) begin
                              done_q  <= 1'b1;
                              pass_q  <= 1'b0;
                              tmo_q   <= 1'b1;
                              state_q <= ST_IDLE;
                           end else begin
                              state_q <= ST_REQ;
                           end
                        end else if (!tog_q) begin
                           phase_q <= PH_FULL;
                           state_q <= ST_SETTLE;
                        end else if (full_match) begin
                           done_q  <= 1'b1;
                           pass_q  <= 1'b1;
                           state_q <= ST_IDLE;
                        end else begin
                           phase_q       <= PH_CONF;
                           conf_second_q <= 1'b0;
                           conf_ok_q     <= 1'b1;
                           state_q       <= ST_REQ;
                        end
                     end
                     PH_FULL: begin
                        if (full_match) begin
                           done_q  <= 1'b1;
                           pass_q  <= 1'b1;
                           state_q <= ST_IDLE;
                        end else begin
                           phase_q       <= PH_CONF;
                           conf_second_q <= 1'b0;
                           conf_ok_q     <= 1'b1;
                           state_q       <= ST_REQ;
                        end
                     end
                     default: begin
                        if (conf_second_q) begin
                           done_q  <= 1'b1;
                           pass_q  <= conf_ok_nx;
                           state_q <= ST_IDLE;
                        end else begin
                           conf_second_q <= 1'b1;
                           conf_ok_q     <= conf_ok_nx;
                           state_q       <= ST_REQ;
                        end
                     end
                  endcase
               end
            end
            ST_SETTLE: begin
               if (settle_done) begin
                  state_q <= ST_REQ;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_req  = (state_q == ST_REQ);
   assign rd_addr = addr_q;
   assign done    = done_q;
   assign pass    = pass_q;
   assign timeout = tmo_q;
endmodule

// File: rtl/wdp_checker.sv
module wdp_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic rd_req,
   input logic rd_valid,
   input logic done,
   input logic pass,
   input logic timeout
);
   // R11: the end-of-job pulse never lasts two cycles
   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4: every read request is a one-cycle pulse
   p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R4: a request and completion never coincide
   p_req_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !done);

   // R10: a timed-out job never reports pass
   p_tmo_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> !pass);

   // R10: timeout rises only together with the end pulse
   p_tmo_rise_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> done);

   // R11: results change only at done or after a start
   p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (done || ($stable(pass) && $stable(timeout))));

   // R9: the end pulse is produced from returned data
   p_done_after_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(rd_valid));
endmodule

bind wr_done_poller wdp_checker u_wdp_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .rd_req   (rd_req),
   .rd_valid (rd_valid),
   .done     (done),
   .pass     (pass),
   .timeout  (timeout)
);

// File: tb/tb_wr_done_poller.sv
module tb_wr_done_poller;
   localparam int ADDR_W = 20;
   localparam int CNT_W  = 16;
   localparam int SETTLE = 12;
   localparam int LAT    = 2;

   logic              clk;
   logic              rst_n;
   logic              start;
   logic [1:0]        mode;
   logic [ADDR_W-1:0] addr_in;
   logic [7:0]        exp_data;
   logic [CNT_W-1:0]  max_polls;
   logic              wr_strobe_n;
   logic              rd_req;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;
   logic              rd_valid;
   logic              done;
   logic              pass;
   logic              timeout;

   wr_done_poller #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE), .DATA_W(8)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .addr_in(addr_in), .exp_data(exp_data), .max_polls(max_polls),
      .wr_strobe_n(wr_strobe_n), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
      .pass(pass), .timeout(timeout)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [7:0]        scr [16];
   logic [ADDR_W-1:0] job_addr;
   int nreq, nval, ndone, lat_left, rise_t, done_t;
   int req_t [40];
   int val_t [40];
   logic pass_s, tmo_s, addr_bad, finished;

   task automatic check(input logic ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
      end
   endtask

   // memory responder and monitors, all on the falling edge
   initial begin
      nreq = 0; nval = 0; ndone = 0; lat_left = 0; addr_bad = 1'b0;
      rd_valid = 1'b0; rd_data = 8'h00;
      forever begin
         @(negedge clk);
         rd_valid = 1'b0;
         if (lat_left > 0) begin
            lat_left--;
            if (lat_left == 0) begin
               rd_data  = scr[(nval > 15) ? 15 : nval];
               rd_valid = 1'b1;
               if (nval < 40) val_t[nval] = cyc;
               nval++;
            end
         end
         if (rd_req) begin
            if (rd_addr != job_addr) addr_bad = 1'b1;
            if (nreq < 40) req_t[nreq] = cyc;
            nreq++;
            lat_left = LAT;
         end
         if (done) begin
            ndone++;
            pass_s = pass;
            tmo_s  = timeout;
            done_t = cyc;
         end
      end
   end

   // reference model of the requirements
   task automatic model(input logic [1:0] md, input logic [7:0] ex, input int maxp,
                        output logic m_pass, output logic m_tmo, output int m_reads,
                        output int m_settle, output logic m_conf);
      int i = 0;
      int busy = 0;
      logic [7:0] tgt, b;
      logic prev;
      logic stable = 1'b0;
      int lim = (maxp == 0) ? 1 : maxp;
      m_settle = -1; m_conf = 1'b0; m_tmo = 1'b0; m_pass = 1'b0;
      tgt = (md == 2'b01) ? 8'hFF : ex;
      b = 8'h00;
      if (md[1]) begin
         prev = scr[0][6]; i = 1;
         while (!stable && !m_tmo) begin
            b = scr[(i > 15) ? 15 : i]; i++;
            if (b[6] == prev) stable = 1'b1;
            else begin busy++; if (busy >= lim) m_tmo = 1'b1; prev = b[6]; end
         end
      end else begin
         while (!stable && !m_tmo) begin
            b = scr[(i > 15) ? 15 : i]; i++;
            if (b[7] == tgt[7]) stable = 1'b1;
            else begin busy++; if (busy >= lim) m_tmo = 1'b1; end
         end
         if (stable) begin
            m_settle = i;
            b = scr[(i > 15) ? 15 : i]; i++;
         end
      end
      if (stable) begin
         if (b == tgt) m_pass = 1'b1;
         else begin
            m_conf = 1'b1;
            m_pass = (scr[(i > 15) ? 15 : i] == tgt) && (scr[(i+1 > 15) ? 15 : i+1] == tgt);
            i += 2;
         end
      end
      m_reads = i;
   endtask

   // script builder: k busy reads then a random tail biased toward the target
   task automatic build(input logic [1:0] md, input logic [7:0] ex, input int k);
      logic [7:0] tgt = (md == 2'b01) ? 8'hFF : ex;
      for (int i = 0; i < 16; i++) scr[i] = 8'($urandom);
      if (md[1]) begin
         for (int i = 1; i <= k && i < 16; i++) scr[i][6] = ~scr[i-1][6];
         if (k + 1 < 16) scr[k+1][6] = scr[k][6];
         for (int i = k + 1; i < 16; i++) if ($urandom % 4 != 0) scr[i] = tgt;
      end else begin
         for (int i = 0; i < k && i < 16; i++) scr[i][7] = ~tgt[7];
         if (k < 16) scr[k][7] = tgt[7];
         for (int i = k + 1; i < 16; i++) if ($urandom % 4 != 0) scr[i] = tgt;
      end
   endtask

   function automatic string mode_tag(input logic [1:0] md);
      if (md[1]) return "R8";
      if (md[0]) return "R6";
      return "R5";
   endfunction

   task automatic run_job(input logic [1:0] md, input logic [7:0] ex, input int maxp,
                          input int strobe_lat, input logic poke);
      logic m_pass, m_tmo, m_conf;
      int m_reads, m_settle, guard;
      string tg;
      model(md, ex, maxp, m_pass, m_tmo, m_reads, m_settle, m_conf);
      tg = m_tmo ? "R10" : (m_conf ? "R9" : mode_tag(md));
      @(negedge clk);
      job_addr = ADDR_W'($urandom);
      mode = md; exp_data = ex; max_polls = CNT_W'(maxp); addr_in = job_addr;
      wr_strobe_n = 1'b0; start = 1'b1;
      nreq = 0; nval = 0; ndone = 0; addr_bad = 1'b0;
      @(negedge clk);
      start = 1'b0; addr_in = ~job_addr; mode = ~md; exp_data = ~ex;
      check(!pass && !timeout, "R2 results cleared", {pass, timeout}, 0);
      repeat (strobe_lat) @(negedge clk);
      wr_strobe_n = 1'b1; rise_t = cyc;
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (ndone == 0 && guard < 4000) begin @(negedge clk); guard++; end
      repeat (6) @(negedge clk);
      check(ndone == 1, "R11 one done pulse", ndone, 1);
      check(pass_s == m_pass, {tg, " pass"}, pass_s, m_pass);
      check(tmo_s == m_tmo, "R10 timeout", tmo_s, m_tmo);
      check(nreq == m_reads, poke ? "R2 reads with ignored start" : {tg, " read count"}, nreq, m_reads);
      check(!addr_bad, "R4 read address", addr_bad, 0);
      check(nreq > 0 && req_t[0] > rise_t, "R3 no read before strobe rise", req_t[0], rise_t + 1);
      if (m_settle >= 1 && m_settle < 40 && nreq > m_settle)
         check(req_t[m_settle] - val_t[m_settle-1] >= SETTLE, "R7 settle gap",
               req_t[m_settle] - val_t[m_settle-1], SETTLE);
      check(pass == pass_s && timeout == tmo_s && nreq == m_reads, "R11 result held",
            {pass, timeout}, {pass_s, tmo_s});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; start = 1'b0; mode = 2'b00; addr_in = '0; exp_data = 8'h00;
      max_polls = '0; wr_strobe_n = 1'b1; job_addr = '0; pass_s = 1'b0; tmo_s = 1'b0;
      for (int i = 0; i < 16; i++) scr[i] = 8'h00;
      repeat (3) @(negedge clk);
      check(!done && !pass && !timeout && !rd_req, "R1 reset outputs", {done, pass, timeout, rd_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !pass && !timeout && !rd_req, "R1 after reset", {done, pass, timeout, rd_req}, 0);

      // directed: program, immediate finish
      build(2'b00, 8'h5A, 0); scr[1] = 8'h5A; run_job(2'b00, 8'h5A, 8, 1, 1'b0);
      // directed: erase with three busy reads
      build(2'b01, 8'h12, 3); scr[4] = 8'hFF; run_job(2'b01, 8'h12, 8, 2, 1'b0);
      // directed: toggle with two busy reads
      build(2'b10, 8'hC3, 2); scr[3] = 8'hC3; scr[3][6] = scr[2][6]; run_job(2'b10, 8'hC3, 8, 1, 1'b0);
      // directed: full mismatch confirmed good twice
      build(2'b00, 8'hA5, 1); scr[2] = 8'hA4; scr[3] = 8'hA5; scr[4] = 8'hA5; run_job(2'b00, 8'hA5, 8, 1, 1'b0);
      // directed: full mismatch, second confirm bad
      build(2'b00, 8'hA5, 1); scr[2] = 8'h25; scr[3] = 8'hA5; scr[4] = 8'h05; run_job(2'b00, 8'hA5, 8, 1, 1'b0);
      // directed: timeout exactly at limit, and limit 0
      build(2'b00, 8'h80, 16); run_job(2'b00, 8'h80, 4, 1, 1'b0);
      build(2'b01, 8'h00, 16); run_job(2'b01, 8'h00, 0, 3, 1'b0);
      // directed: start during a job is ignored
      build(2'b00, 8'h3C, 4); scr[5] = 8'h3C; run_job(2'b00, 8'h3C, 10, 1, 1'b1);

      for (int n = 0; n < 40; n++) begin
         logic [1:0] md = 2'($urandom);
         logic [7:0] ex = 8'($urandom);
         int k = $urandom % 7;
         int mp = $urandom % 8;
         build(md, ex, k);
         run_job(md, ex, mp, 1 + ($urandom % 4), ($urandom % 5) == 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule